// File: doc/BRIEF.md
# MII Receive Destination-Address Filter

This block sits beside an Ethernet MAC and listens to the 4-bit MII receive bus, which it cannot stall. It takes its timing from a start strobe that the MAC drives low for a single receive clock partway into each frame. Counting from that strobe, it collects the twelve nibbles of the destination address and rebuilds the 48-bit address. It then compares the address against a small table of programmable entries, all entries at once. When the frame has no home, the block pulls an active-low reject line for one receive clock so the MAC drops the frame.

The receive stream is qualified by `rx_dv` alone. The filter only observes the bus and offers no ready signal, so back-pressure is not possible. A nibble counts only when `rx_dv` is high, and a low `rx_dv` ends the frame. The table load port, the filter enable and the broadcast enable are plain level or strobe pins. Table loads are honoured only while no frame is on the bus.

Top module: `mii_da_filter`

## Requirements
- R1: After reset `reject_n` is 1 and every table entry is invalid, so a frame carrying any address, including all zeros, is rejected.
- R2: The receive clock in which `sof_n` is low (with `rx_dv` high) is offset 0. The address nibbles are the twelve consecutive nibbles starting at offset `DA_OFS` (default 0). A later strobe redefines offset 0.
- R3: Nibble k of the address (k = 0..11) belongs to byte k/2, and byte 0 is bits 47:40. An even k carries the byte's bits 3:0 and an odd k carries bits 7:4.
- R4: On a miss, `reject_n` is 0 for exactly one receive clock. That clock is offset `DA_OFS`+13 and it is never repeated.
- R5: An address that equals a valid table entry is not rejected. An entry whose valid bit is 0 never matches.
- R6: When `bcast_en` is 1, the all-ones address is accepted without a table hit. When `bcast_en` is 0, the all-ones address is rejected unless the table holds it.
- R7: While `filt_en` is 0, `reject_n` stays 1.
- R8: When `rx_dv` goes low, capture is aborted and no reject is produced for that frame. This also holds when `rx_dv` drops in the cycle in which the comparison would be made.
- R9: A strobe that arrives during capture restarts capture. A strobe that arrives in the comparison cycle cancels the pending verdict.
- R10: A table write (`cfg_we` = 1) made while `rx_dv` is 1 is ignored. The same write made while `rx_dv` is 0 takes effect.
- R11: The strobe nibble is packet nibble `STROBE_NIB` (5). `reject_n` is never driven low in a clock whose packet nibble number exceeds `LAST_NIB` (128). A verdict that would land later is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | MII receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 4 | MII receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| sof_n | input | 1 | Active-low start strobe from the MAC, low for one nibble |
| filt_en | input | 1 | Filter enable; when 0, no reject is produced |
| bcast_en | input | 1 | Accept the all-ones address |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(ENTRIES) | Table entry index |
| cfg_addr | input | 48 | Address written to the entry |
| cfg_vld | input | 1 | Valid bit written to the entry |
| reject_n | output | 1 | Active-low frame reject to the MAC |

## Verification
The assertions check these on every cycle:
- a reject lasts one clock;
- a reject follows only a cycle in which `filt_en` and `rx_dv` were high and no new strobe arrived;
- a reject never lands beyond nibble 128;
- the comparison fires at the fixed nibble after the strobe;
- a table write attempted during a frame leaves the table unchanged.

Only the scenarios can show the rest. That covers the address value that is actually assembled, including nibble order and byte order. It also covers whether a hit, an invalid entry or broadcast gives the right verdict, and the exact cycle of each reject. A second instance with a late address offset shows the nibble-128 cut-off.

// File: rtl/mii_filt_pkg.sv
package mii_filt_pkg;
  localparam int NIB_W    = 4;
  localparam int MAC_W    = 48;
  localparam int MAC_NIBS = MAC_W / NIB_W;

  typedef logic [MAC_W-1:0] mac_t;

  typedef struct packed {
    logic vld;
    mac_t addr;
  } cam_ent_t;
endpackage

// File: rtl/mii_da_capture.sv
module mii_da_capture
  import mii_filt_pkg::*;
#(
  parameter int DA_OFS     = 0,
  parameter int STROBE_NIB = 5,
  parameter int POS_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] rxd,
  input  logic             rx_dv,
  input  logic             sof_n,
  output mac_t             da,
  output logic             da_ready,
  output logic [POS_W-1:0] nib_pos
);
  localparam int SPAN      = DA_OFS + MAC_NIBS;
  localparam int CW        = $clog2(SPAN + 1);
  localparam int IW        = $clog2(MAC_NIBS);
  localparam int POS_MAX   = (1 << POS_W) - 1;
  localparam int READY_RAW = STROBE_NIB + SPAN;
  localparam int READY_POS = (READY_RAW >= POS_MAX) ? POS_MAX : READY_RAW;

  logic          active;
  logic [CW-1:0] cnt;
  int            kk;
  logic          in_win;
  logic [IW-1:0] idx;
  int            base;

  // Offset of the nibble on the bus in this cycle; a strobe restarts at 0.
  always_comb begin
    kk     = sof_n ? int'(cnt) : 0;
    in_win = rx_dv && (!sof_n || active) && (kk >= DA_OFS) && (kk < SPAN);
    idx    = IW'(kk - DA_OFS);
    // Byte 0 is most significant; low nibble of each byte arrives first.
    base   = MAC_W - 8 - 8 * (int'(idx) / 2) + 4 * int'(idx[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      da_ready <= 1'b0;
      nib_pos  <= '0;
      da       <= '0;
    end else begin
      da_ready <= in_win && (idx == IW'(MAC_NIBS - 1));
      if (in_win) da[base +: NIB_W] <= rxd;
      if (!rx_dv) begin
        active  <= 1'b0;
        cnt     <= '0;
        nib_pos <= '0;
      end else begin
        if (!sof_n)
          nib_pos <= POS_W'(STROBE_NIB + 1);
        else if (nib_pos != '0 && nib_pos != '1)
          nib_pos <= nib_pos + 1'b1;
        if (!sof_n || active) begin
          active <= (kk + 1 < SPAN);
          cnt    <= CW'(kk + 1);
        end
      end
    end
  end

  assert_strobe_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && !sof_n) |=> (nib_pos == POS_W'(STROBE_NIB + 1)));

  assert_ready_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    da_ready |-> (nib_pos == POS_W'(READY_POS)));
endmodule

// File: rtl/mii_addr_table.sv
module mii_addr_table
  import mii_filt_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busy,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  mac_t                       wr_addr,
  input  logic                       wr_vld,
  input  mac_t                       key,
  output logic                       hit
);
  cam_ent_t [ENTRIES-1:0] tab;
  logic     [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab <= '0;
    end else if (wr_en && !busy && int'(wr_idx) < ENTRIES) begin
      tab[wr_idx] <= '{vld: wr_vld, addr: wr_addr};
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = tab[g].vld && (tab[g].addr == key);
  end

  assign hit = |match;

  assert_write_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(tab));
endmodule

// File: rtl/mii_da_filter.sv
module mii_da_filter
  import mii_filt_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int DA_OFS     = 0,
  parameter int STROBE_NIB = 5,
  parameter int LAST_NIB   = 128,
  parameter int POS_W      = 8
) (
  input  logic                       rx_clk,
  input  logic                       rst_n,
  input  logic [3:0]                 rxd,
  input  logic                       rx_dv,
  input  logic                       sof_n,
  input  logic                       filt_en,
  input  logic                       bcast_en,
  input  logic                       cfg_we,
  input  logic [$clog2(ENTRIES)-1:0] cfg_idx,
  input  logic [47:0]                cfg_addr,
  input  logic                       cfg_vld,
  output logic                       reject_n
);
  mac_t             da;
  logic             da_ready;
  logic [POS_W-1:0] nib_pos;
  logic             hit;
  logic             miss;
  logic             fire;

  mii_da_capture #(
    .DA_OFS(DA_OFS), .STROBE_NIB(STROBE_NIB), .POS_W(POS_W)
  ) u_cap (
    .clk(rx_clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .sof_n(sof_n),
    .da(da), .da_ready(da_ready), .nib_pos(nib_pos)
  );

  mii_addr_table #(.ENTRIES(ENTRIES)) u_tab (
    .clk(rx_clk), .rst_n(rst_n), .busy(rx_dv), .wr_en(cfg_we),
    .wr_idx(cfg_idx), .wr_addr(cfg_addr), .wr_vld(cfg_vld),
    .key(da), .hit(hit)
  );

  // The verdict lands one clock after the comparison; that clock must not pass LAST_NIB.
  always_comb begin
    miss = !(hit || (bcast_en && (&da)));
    fire = da_ready && sof_n && rx_dv && filt_en && miss &&
           (int'(nib_pos) < LAST_NIB);
  end

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) reject_n <= 1'b1;
    else        reject_n <= !fire;
  end

  assert_single_pulse_R4: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !reject_n |=> reject_n);

  assert_enable_gate_R7: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !reject_n |-> $past(filt_en));

  assert_dv_abort_R8: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !reject_n |-> $past(rx_dv));

  assert_restart_cancel_R9: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !reject_n |-> $past(sof_n));

  assert_nibble_window_R11: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !reject_n |-> (int'(nib_pos) <= LAST_NIB));
endmodule

// File: tb/mii_da_filter_test.sv
module mii_da_filter_test;
  import mii_filt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LATE_OFS   = 111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rxd = '0;
  logic        rx_dv = 1'b0, sof_n = 1'b1, filt_en = 1'b0, bcast_en = 1'b0;
  logic        cfg_we = 1'b0, cfg_vld = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [47:0] cfg_addr = '0;
  logic        reject_n, late_reject_n;

  int cyc = 0, n_cmp = 0, n_bad = 0, late_lows = 0;
  int    exp_cyc[$];
  string exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mii_da_filter uut (
    .rx_clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .sof_n(sof_n),
    .filt_en(filt_en), .bcast_en(bcast_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_vld(cfg_vld), .reject_n(reject_n)
  );

  mii_da_filter #(.DA_OFS(LATE_OFS)) uut_late (
    .rx_clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .sof_n(sof_n),
    .filt_en(filt_en), .bcast_en(bcast_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_vld(cfg_vld), .reject_n(late_reject_n)
  );

  // Monitor: every reject must match the head of the expectation queue.
  always @(negedge clk) begin
    if (rst_n && reject_n === 1'b0) begin
      n_cmp++;
      if (exp_cyc.size() == 0) begin
        n_bad++;
        $display("FAIL R4 unexpected reject at cycle %0d: reject_n=0, expected 1", cyc);
      end else begin
        int    e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (e != cyc) begin
          n_bad++;
          $display("FAIL %s reject cycle: actual %0d, expected %0d", t, cyc, e);
        end
      end
    end
    if (rst_n && late_reject_n === 1'b0) late_lows++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d, expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input mac_t da, input int i);
    logic [7:0] b;
    b = da[47 - 8*(i/2) -: 8];
    return (i % 2) ? b[7:4] : b[3:0];
  endfunction

  task automatic drive(input logic [3:0] nib, input bit sof);
    @(negedge clk);
    rxd = nib; sof_n = !sof; rx_dv = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_dv = 1'b0; sof_n = 1'b1; rxd = '0;
    end
  endtask

  task automatic expect_rej(input int s, input string tag);
    exp_cyc.push_back(s + 13);
    exp_tag.push_back(tag);
  endtask

  task automatic frame_end(input string tag);
    idle(5);
    check(exp_cyc.size() == 0, tag, "missing reject, pending count", exp_cyc.size(), 0);
    exp_cyc.delete();
    exp_tag.delete();
  endtask

  // Four lead-in nibbles, then the strobe on the first address nibble.
  task automatic send_da(input mac_t da, input bit rej, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      drive(nib_of(da, i), i == 0);
      if (i == 0 && rej) expect_rej(cyc, tag);
    end
  endtask

  task automatic lead_in();
    for (int i = 0; i < 4; i++) drive(4'h5, 1'b0);
  endtask

  task automatic payload(input int n);
    for (int i = 0; i < n; i++) drive(i[3:0], 1'b0);
  endtask

  task automatic send_frame(input mac_t da, input bit rej, input string tag, input int pay);
    lead_in();
    send_da(da, rej, tag, 12);
    payload(pay);
    frame_end(tag);
  endtask

  task automatic cfg_write(input int idx, input mac_t a, input bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_addr = a; cfg_vld = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  localparam mac_t A0 = 48'h0011_2233_4455;
  localparam mac_t A3 = 48'hA1B2_C3D4_E5F6;
  localparam mac_t A5 = 48'h0203_0405_0607;
  localparam mac_t UNK = 48'h7E57_0000_BEEF;
  localparam mac_t X1 = 48'h0A0B_0C0D_0E0F;

  initial begin
    repeat (3) @(negedge clk);
    check(reject_n === 1'b1, "R1", "reject_n in reset", reject_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(reject_n === 1'b1, "R1", "reject_n after reset", reject_n, 1);
    filt_en = 1'b1;
    send_frame(48'h0, 1'b1, "R1", 20);   // empty table: all-zero address misses

    cfg_write(0, A0, 1'b1);
    cfg_write(3, A3, 1'b1);
    cfg_write(5, A5, 1'b0);

    send_frame(A0, 1'b0, "R5", 20);
    send_frame(A3, 1'b0, "R3", 20);
    send_frame(48'h1A2B_3C4D_5E6F, 1'b1, "R3", 20);  // nibbles swapped in each byte
    send_frame(48'hF6E5_D4C3_B2A1, 1'b1, "R3", 20);  // bytes reversed
    send_frame(UNK, 1'b1, "R4", 20);
    send_frame(A5, 1'b1, "R5", 20);                  // entry present but invalid

    bcast_en = 1'b1;
    send_frame('1, 1'b0, "R6", 20);
    bcast_en = 1'b0;
    send_frame('1, 1'b1, "R6", 20);

    filt_en = 1'b0;
    send_frame(UNK, 1'b0, "R7", 20);
    filt_en = 1'b1;

    // R8: rx_dv drops mid-address, and drops in the comparison cycle.
    lead_in(); send_da(UNK, 1'b0, "R8", 8); frame_end("R8");
    lead_in(); send_da(UNK, 1'b0, "R8", 12); frame_end("R8");

    // R9: restart mid-capture, then restart in the comparison cycle.
    lead_in(); send_da(UNK, 1'b0, "R9", 6); send_da(A0, 1'b0, "R9", 12);
    payload(10); frame_end("R9");
    lead_in(); send_da(UNK, 1'b0, "R9", 12); send_da(A0, 1'b0, "R9", 12);
    payload(10); frame_end("R9");
    // R2: second strobe realigns; verdict timed from it.
    lead_in(); send_da(A0, 1'b0, "R2", 5); send_da(UNK, 1'b1, "R2", 12);
    payload(10); frame_end("R2");
    // R2: address bytes shifted by one nibble relative to the strobe are not a hit.
    lead_in(); drive(4'h0, 1'b1); expect_rej(cyc, "R2");
    for (int i = 0; i < 11; i++) drive(nib_of(A0, i), 1'b0);
    payload(10); frame_end("R2");

    // R10: write attempted during a frame is dropped.
    lead_in(); send_da(A0, 1'b0, "R10", 12);
    @(negedge clk);
    rxd = 4'h3; sof_n = 1'b1; rx_dv = 1'b1;
    cfg_we = 1'b1; cfg_idx = 3'd1; cfg_addr = X1; cfg_vld = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rxd = 4'h4;
    payload(8); frame_end("R10");
    send_frame(X1, 1'b1, "R10", 20);
    cfg_write(1, X1, 1'b1);
    send_frame(X1, 1'b0, "R10", 20);

    // R11: long frame; late-offset instance would reach nibble 129.
    late_lows = 0;
    send_frame(UNK, 1'b1, "R11", 150);
    check(late_lows == 0, "R11", "late instance reject clocks", late_lows, 0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
    summary();
    $finish;
  end
endmodule